// File: doc/BRIEF.md
# Matrix-Decoded Digital Potentiometer Controller

This block is the digital control for a resistor-string potentiometer that has 256 taps. It keeps an 8-bit wiper code and turns it into two one-hot groups of select lines for a 16 by 16 tap matrix. The upper half of the code picks one of 16 row lines and the lower half picks one of 16 column lines. The analog side therefore needs 32 control lines rather than 256, and the pair of active lines selects exactly one tap.

The wiper code can be loaded in two ways. The first is a parallel write port with a valid/ready handshake. Its ready output is held high permanently, so a beat is accepted on every clock edge where valid is high and the port never applies back-pressure. The second is an SPI mode 0 serial port that takes 16-bit command frames. A frame can write the code, step it up or step it down. A step stops at the end of the range and does not wrap. The wiper register is volatile: every reset returns it to mid-scale (0x80).

The serial pins are synchronised into the system clock domain. The serial clock must therefore run well below the system clock (each serial clock phase should last at least three system clocks).

Top module: `digipot_ctrl`

## Requirements
- R1: During and after reset the wiper code is 0x80, row line 8 is the only active row and column line 0 is the only active column.
- R2: Outside reset, exactly one bit of `row_sel` and exactly one bit of `col_sel` are high in every cycle.
- R3: `row_sel` is the one-hot form of wiper bits [7:4] and `col_sel` is the one-hot form of wiper bits [3:0]. Both change on the same clock edge, one cycle after the wiper code changes.
- R4: `par_ready` is always high. On a clock edge where `par_valid` is high, the wiper code takes the value of `par_data`.
- R5: A serial frame is framed by `spi_cs_n` low. Bits are sampled on rising edges of `spi_sclk`, MSB first. Frame bits [15:12] are the command, bits [11:8] are reserved and bits [7:0] are the data. The command acts only after `spi_cs_n` rises.
- R6: Command 0x1 loads the frame data into the wiper code.
- R7: Command 0x2 adds one to the wiper code. At 0xFF the code stays at 0xFF.
- R8: Command 0x3 subtracts one from the wiper code. At 0x00 the code stays at 0x00.
- R9: Command 0x0 and commands 0x4 to 0xF leave the wiper code unchanged. The reserved bits have no effect on any command.
- R10: A frame that does not hold exactly 16 sampled bits when `spi_cs_n` rises is discarded, and the wiper code is unchanged.
- R11: If a parallel write and a completed serial command reach the wiper register in the same cycle, the parallel write wins and the serial command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_valid | input | 1 | Parallel write beat valid |
| par_data | input | 8 | Parallel wiper code |
| par_ready | output | 1 | Parallel write accept, always high |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| wiper | output | 8 | Current wiper code |
| row_sel | output | 16 | One-hot row select |
| col_sel | output | 16 | One-hot column select |

## Verification
The assertions check the following on every cycle:
- the one-hot property of both select groups, and that each group follows the code registered one cycle earlier;
- that a step at either end of the range holds its value;
- that a no-operation leaves the code unchanged;
- that a parallel beat always determines the next code.

Only the bench's scenarios can show that serial frames are decoded with the right bit order and field positions. The same holds for discarding frames that are too short or too long, and for landing a parallel beat on the exact cycle a serial command completes.

// File: rtl/digipot_pkg.sv
package digipot_pkg;
  localparam int CMD_W = 4;
  localparam logic [CMD_W-1:0] OP_NOP  = 4'h0;
  localparam logic [CMD_W-1:0] OP_LOAD = 4'h1;
  localparam logic [CMD_W-1:0] OP_UP   = 4'h2;
  localparam logic [CMD_W-1:0] OP_DOWN = 4'h3;
endpackage

// File: rtl/digipot_spi_rx.sv
module digipot_spi_rx
  import digipot_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int FRAME_BITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_op,
  output logic [CODE_W-1:0] cmd_arg
);
  localparam int CNT_W   = $clog2(FRAME_BITS + 2);
  localparam int CNT_MAX = FRAME_BITS + 1;

  logic [1:0] sclk_s, cs_s, mosi_s;
  logic       sclk_d, cs_d;
  logic [CNT_W-1:0]  bit_cnt;
  logic [CMD_W-1:0]  op_sh;
  logic [CODE_W-1:0] arg_sh;
  logic sclk_rise, cs_rise;

  assign sclk_rise = sclk_s[1] & ~sclk_d;
  assign cs_rise   = cs_s[1] & ~cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_s <= {sclk_s[0], sclk};
      cs_s   <= {cs_s[0], cs_n};
      mosi_s <= {mosi_s[0], mosi};
      sclk_d <= sclk_s[1];
      cs_d   <= cs_s[1];
    end
  end

  // Command bits are captured from the first CMD_W samples; all later
  // samples pass through arg_sh, so reserved bits fall out of its top.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      op_sh   <= '0;
      arg_sh  <= '0;
    end else if (cs_s[1]) begin
      bit_cnt <= '0;
    end else if (sclk_rise) begin
      if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt < CNT_W'(CMD_W)) op_sh <= {op_sh[CMD_W-2:0], mosi_s[1]};
      arg_sh <= {arg_sh[CODE_W-2:0], mosi_s[1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_op    <= OP_NOP;
      cmd_arg   <= '0;
    end else begin
      cmd_valid <= cs_rise && (bit_cnt == CNT_W'(FRAME_BITS));
      if (cs_rise) begin
        cmd_op  <= op_sh;
        cmd_arg <= arg_sh;
      end
    end
  end

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
endmodule

// File: rtl/digipot_wiper.sv
module digipot_wiper
  import digipot_pkg::*;
#(
  parameter int                CODE_W   = 8,
  parameter logic [CODE_W-1:0] RST_CODE = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_valid,
  input  logic [CODE_W-1:0] par_data,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_op,
  input  logic [CODE_W-1:0] cmd_arg,
  output logic [CODE_W-1:0] code_q
);
  localparam logic [CODE_W-1:0] TOP = '1;

  logic [CODE_W-1:0] code_d;

  always_comb begin
    code_d = code_q;
    if (par_valid) begin
      code_d = par_data;
    end else if (cmd_valid) begin
      case (cmd_op)
        OP_LOAD: code_d = cmd_arg;
        OP_UP:   if (code_q != TOP) code_d = code_q + 1'b1;
        OP_DOWN: if (code_q != '0)  code_d = code_q - 1'b1;
        default: code_d = code_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= RST_CODE;
    else        code_q <= code_d;
  end

  p_par_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    par_valid |=> code_q == $past(par_data));
  p_up_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !par_valid && cmd_op == OP_UP && code_q == TOP) |=> code_q == TOP);
  p_down_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !par_valid && cmd_op == OP_DOWN && code_q == '0) |=> code_q == '0);
  p_nop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_valid && (!cmd_valid || cmd_op == OP_NOP || cmd_op > OP_DOWN)) |=> $stable(code_q));
endmodule

// File: rtl/digipot_tap_decode.sv
module digipot_tap_decode #(
  parameter int                CODE_W   = 8,
  parameter logic [CODE_W-1:0] RST_CODE = 8'h80
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CODE_W-1:0]           code,
  output logic [(1<<(CODE_W/2))-1:0]  row_sel,
  output logic [(1<<(CODE_W/2))-1:0]  col_sel
);
  localparam int HALF  = CODE_W / 2;
  localparam int LINES = 1 << HALF;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_sel[g] <= (HALF'(g) == RST_CODE[CODE_W-1:HALF]);
        col_sel[g] <= (HALF'(g) == RST_CODE[HALF-1:0]);
      end else begin
        row_sel[g] <= (HALF'(g) == code[CODE_W-1:HALF]);
        col_sel[g] <= (HALF'(g) == code[HALF-1:0]);
      end
    end
  end

  p_one_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(row_sel) == 1);
  p_one_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(col_sel) == 1);
  p_row_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> row_sel[$past(code[CODE_W-1:HALF])]);
  p_col_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> col_sel[$past(code[HALF-1:0])]);
endmodule

// File: rtl/digipot_ctrl.sv
module digipot_ctrl
  import digipot_pkg::*;
#(
  parameter int                CODE_W     = 8,
  parameter int                FRAME_BITS = 16,
  parameter logic [CODE_W-1:0] RST_CODE   = 8'h80,
  localparam int               LINES      = 1 << (CODE_W / 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_valid,
  input  logic [CODE_W-1:0] par_data,
  output logic              par_ready,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic [CODE_W-1:0] wiper,
  output logic [LINES-1:0]  row_sel,
  output logic [LINES-1:0]  col_sel
);
  logic              cmd_valid;
  logic [CMD_W-1:0]  cmd_op;
  logic [CODE_W-1:0] cmd_arg;

  assign par_ready = 1'b1;

  digipot_spi_rx #(.CODE_W(CODE_W), .FRAME_BITS(FRAME_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg)
  );

  digipot_wiper #(.CODE_W(CODE_W), .RST_CODE(RST_CODE)) u_wiper (
    .clk(clk), .rst_n(rst_n), .par_valid(par_valid), .par_data(par_data),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg), .code_q(wiper)
  );

  digipot_tap_decode #(.CODE_W(CODE_W), .RST_CODE(RST_CODE)) u_dec (
    .clk(clk), .rst_n(rst_n), .code(wiper), .row_sel(row_sel), .col_sel(col_sel)
  );
endmodule

// File: tb/digipot_ctrl_test.sv
module digipot_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic par_valid = 1'b0;
  logic [7:0] par_data = '0;
  logic par_ready;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic [7:0] wiper;
  logic [15:0] row_sel, col_sel;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  digipot_ctrl uut (
    .clk(clk), .rst_n(rst_n), .par_valid(par_valid), .par_data(par_data),
    .par_ready(par_ready), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .wiper(wiper), .row_sel(row_sel), .col_sel(col_sel)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_tap(string tag, logic [7:0] code);
    chk({tag, " wiper"}, 32'(wiper), 32'(code));
    chk({tag, " row"}, 32'(row_sel), 32'(16'b1 << code[7:4]));
    chk({tag, " col"}, 32'(col_sel), 32'(16'b1 << code[3:0]));
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic par_write(logic [7:0] d);
    @(negedge clk); par_valid = 1'b1; par_data = d;
    @(negedge clk); par_valid = 1'b0;
    ticks(2);
  endtask

  task automatic spi_body(logic [31:0] word, int nbits);
    @(negedge clk); spi_cs_n = 1'b0;
    ticks(HOLD);
    for (int i = nbits - 1; i >= 0; i--) begin
      spi_mosi = word[i];
      ticks(HOLD); spi_sclk = 1'b1;
      ticks(HOLD); spi_sclk = 1'b0;
    end
    ticks(HOLD);
  endtask

  task automatic spi_frame(logic [31:0] word, int nbits);
    spi_body(word, nbits);
    spi_cs_n = 1'b1;
    ticks(10);
  endtask

  task automatic t_reset;
    chk_tap("R1 reset", 8'h80);
    chk("R4 ready", 32'(par_ready), 32'd1);
  endtask

  task automatic t_parallel;
    logic [15:0] row_before = row_sel, col_before = col_sel;
    @(negedge clk); par_valid = 1'b1; par_data = 8'h3B;
    @(negedge clk); par_valid = 1'b0;
    chk("R4 wiper after one edge", 32'(wiper), 32'h3B);
    chk("R3 row lags one cycle", 32'(row_sel), 32'(row_before));
    chk("R3 col lags one cycle", 32'(col_sel), 32'(col_before));
    @(negedge clk);
    chk_tap("R3 both groups next edge", 8'h3B);
    par_write(8'hF0); chk_tap("R4 write F0", 8'hF0);
    par_write(8'h0F); chk_tap("R4 write 0F", 8'h0F);
  endtask

  task automatic t_serial_write;
    spi_frame(32'h1_0_A5, 16); chk_tap("R6 load A5", 8'hA5);
    spi_frame(32'h1_F_12, 16); chk_tap("R5 R9 reserved ignored", 8'h12);
  endtask

  task automatic t_steps;
    spi_frame(32'h2_0_00, 16); chk_tap("R7 up", 8'h13);
    spi_frame(32'h3_0_00, 16); chk_tap("R8 down", 8'h12);
    spi_frame(32'h1_0_FE, 16);
    spi_frame(32'h2_0_00, 16); chk_tap("R7 up to top", 8'hFF);
    spi_frame(32'h2_0_00, 16); chk_tap("R7 saturate top", 8'hFF);
    spi_frame(32'h1_0_01, 16);
    spi_frame(32'h3_0_00, 16); chk_tap("R8 down to zero", 8'h00);
    spi_frame(32'h3_0_55, 16); chk_tap("R8 saturate zero", 8'h00);
  endtask

  task automatic t_nop;
    spi_frame(32'h1_0_66, 16);
    spi_frame(32'h0_0_99, 16); chk_tap("R9 nop", 8'h66);
    spi_frame(32'h7_0_99, 16); chk_tap("R9 unused op 7", 8'h66);
    spi_frame(32'hF_F_99, 16); chk_tap("R9 unused op F", 8'h66);
  endtask

  task automatic t_bad_len;
    spi_frame(32'h1_0_C3 >> 1, 15); chk_tap("R10 short frame", 8'h66);
    spi_frame({16'h1_0_C3, 1'b1}, 17); chk_tap("R10 long frame", 8'h66);
    spi_frame(32'h1_0_C3, 16); chk_tap("R10 full frame after", 8'hC3);
  endtask

  task automatic t_priority;
    par_write(8'h10);
    spi_body(32'h1_0_AA, 16);
    spi_cs_n = 1'b1;
    ticks(2);
    par_valid = 1'b1; par_data = 8'h5C;
    ticks(2);
    par_valid = 1'b0;
    ticks(4);
    chk_tap("R11 parallel beats serial", 8'h5C);
  endtask

  initial begin
    ticks(3);
    t_reset();
    rst_n = 1'b1;
    ticks(2);
    t_reset();
    t_parallel();
    t_serial_write();
    t_steps();
    t_nop();
    t_bad_len();
    t_priority();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule